// File: doc/BRIEF.md
# External-Clock Synchronous Serial Transmitter

This block sends 8-bit frames over a serial line whose bit clock comes from the peer device. The incoming serial clock is resampled in the system clock domain and passed through an edge detector. Each detected falling edge moves the next bit onto the data output, least significant bit first. Each detected rising edge marks the point where the peer samples that bit.

Software side: a write strobe loads a one-byte holding buffer. The transmitter moves the buffer into its shift register when it needs a frame, sets an interrupt flag, and reports the buffer as empty again. As long as the next byte is in the buffer when the eighth bit has been sampled, frames follow each other with no idle pulse between them. When no byte is waiting, the transmitter parks the line high and ignores the serial clock until software writes again. A write to a full buffer is discarded and sets a sticky overrun flag.

The controller has three states:
- `ST_IDLE`: line high, clock ignored.
- `ST_ARMED`: a bit is queued and the block waits for a falling edge.
- `ST_BIT`: a bit is on the line and the block waits for a rising edge.

It has five transitions:
- IDLE→ARMED: a byte is taken from the buffer.
- ARMED→BIT: a falling edge drives the next bit.
- BIT→ARMED: a rising edge with bits left.
- BIT→ARMED with a reload: a rising edge on the last bit while the buffer is full.
- BIT→IDLE: a rising edge on the last bit while the buffer is empty.

Top module: `ext_sync_tx`

## Requirements
- R1: With `rst` high at a clock edge, the block enters idle with the following outputs: `sdo`=1, `buf_empty`=1, `irq_flag`=0, `ovr_err`=0, `tx_idle`=1.
- R2: Bit i of the frame byte (i=0..7, bit 0 first) is placed on `sdo` after the i-th detected falling edge of `sclk_in` in the frame. `sdo` changes only on a detected edge, so it holds steady across the rising edge that samples it.
- R3: A byte written at least 5 PCLK cycles before the first falling edge of a frame is sent correctly, provided each clock phase lasts at least 4 PCLK cycles.
- R4: A byte written before the falling edge that starts bit 7 of the current frame is sent as the next frame. Its bit 0 follows the very next falling edge, with no gap.
- R5: A byte written while the clock is low during bit 7 is still sent as the next frame with no gap, when the bit-7 high phase lasts at least 4 PCLK cycles.
- R6: `irq_flag` goes high one cycle after the buffer is moved into the shift register and stays high until `irq_clr`. A new transfer in the same cycle as `irq_clr` wins.
- R7: `buf_empty` goes low in the cycle after an accepted write and high again once the byte has been moved into the shift register.
- R8: When bit 7 has been sampled and no byte is waiting, the block returns to idle with `sdo`=1 and `tx_idle`=1. Clock edges in idle do not change `sdo`.
- R9: A write while the buffer is full, and not being emptied that cycle, is discarded. It sets `ovr_err`, which stays set until `err_clr`. The discarded byte is never sent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock (PCLK) |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Buffer write strobe |
| wr_data | input | 8 | Byte to load into the buffer |
| irq_clr | input | 1 | Clears the transmit interrupt flag |
| err_clr | input | 1 | Clears the overrun flag |
| sclk_in | input | 1 | Serial clock supplied from outside, idle high |
| sdo | output | 1 | Serial data out, idle high |
| buf_empty | output | 1 | Holding buffer can take a byte |
| irq_flag | output | 1 | Byte moved into the shift register |
| ovr_err | output | 1 | Sticky overrun flag |
| tx_idle | output | 1 | Transmitter idle, clock ignored |

## Verification
The bench builds the block with its defaults: `DATA_W`=8, `SYNC_STAGES`=2 and `SCLK_IDLE`=1. With these values, a pin edge reaches `sdo` three PCLK cycles after it occurs. Clock phases of 4 to 7 cycles therefore probe the minimum start margin and the short bit-7 high phase right at their limits. Random frame chains with random phase widths exercise the reload path repeatedly. Directed cases cover a write during the bit-7 low phase, a write to a full buffer, and edges seen while idle.

// File: rtl/ext_sync_tx_pkg.sv
package ext_sync_tx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_BIT   = 2'd2
    } tx_state_e;

endpackage

// File: rtl/sclk_sync.sv
module sclk_sync #(
    parameter int   STAGES   = 2,
    parameter logic IDLE_LVL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_i,
    output logic rise_o,
    output logic fall_o
);
    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain_q <= {STAGES{IDLE_LVL}};
            prev_q  <= IDLE_LVL;
        end else begin
            for (int i = 0; i < STAGES; i++) begin
                chain_q[i] <= (i == 0) ? pin_i : chain_q[(i == 0) ? 0 : i - 1];
            end
            prev_q <= chain_q[LAST];
        end
    end

    assign rise_o = chain_q[LAST] & ~prev_q;
    assign fall_o = ~chain_q[LAST] & prev_q;

endmodule

// File: rtl/tx_buffer.sv
module tx_buffer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         take_i,
    input  logic         err_clr,
    output logic [W-1:0] data_o,
    output logic         full_o,
    output logic         ovr_o
);
    logic         accept;
    logic         clash;

    assign accept = wr_en & (~full_o | take_i);
    assign clash  = wr_en & full_o & ~take_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            data_o <= '0;
            full_o <= 1'b0;
            ovr_o  <= 1'b0;
        end else begin
            if (accept) begin
                data_o <= wr_data;
                full_o <= 1'b1;
            end else if (take_i) begin
                full_o <= 1'b0;
            end
            if (clash) begin
                ovr_o <= 1'b1;
            end else if (err_clr) begin
                ovr_o <= 1'b0;
            end
        end
    end

    // R9
    ovr_set_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && full_o && !take_i) |=> (ovr_o && $stable(data_o)));

    // R7
    take_empty_chk: assert property (@(posedge clk) disable iff (rst)
        (take_i && !wr_en) |=> !full_o);

endmodule

// File: rtl/tx_shift_fsm.sv
module tx_shift_fsm
    import ext_sync_tx_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         rise_i,
    input  logic         fall_i,
    input  logic         buf_full_i,
    input  logic [W-1:0] buf_data_i,
    input  logic         irq_clr,
    output logic         take_o,
    output logic         sdo_o,
    output logic         irq_o,
    output logic         idle_o
);
    localparam int CW = (W > 1) ? $clog2(W) : 1;
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    tx_state_e     state_q, state_d;
    logic [W-1:0]  shift_q;
    logic [CW-1:0] idx_q;
    logic          frame_end;

    assign frame_end = (state_q == ST_BIT) && rise_i && (idx_q == LAST);

    always_comb begin
        state_d = state_q;
        take_o  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (buf_full_i) begin
                    take_o  = 1'b1;
                    state_d = ST_ARMED;
                end
            end
            ST_ARMED: begin
                if (fall_i) state_d = ST_BIT;
            end
            ST_BIT: begin
                if (rise_i) begin
                    if (idx_q != LAST) begin
                        state_d = ST_ARMED;
                    end else if (buf_full_i) begin
                        take_o  = 1'b1;
                        state_d = ST_ARMED;
                    end else begin
                        state_d = ST_IDLE;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            shift_q <= '0;
            idx_q   <= '0;
            sdo_o   <= 1'b1;
            irq_o   <= 1'b0;
        end else begin
            if (state_q == ST_ARMED && fall_i) begin
                sdo_o   <= shift_q[0];
                shift_q <= shift_q >> 1;
            end
            if (take_o) begin
                shift_q <= buf_data_i;
                idx_q   <= '0;
            end else if (state_q == ST_BIT && rise_i) begin
                idx_q <= idx_q + 1'b1;
            end
            if (frame_end && !buf_full_i) begin
                sdo_o <= 1'b1;
            end
            if (take_o) begin
                irq_o <= 1'b1;
            end else if (irq_clr) begin
                irq_o <= 1'b0;
            end
        end
    end

    assign idle_o = (state_q == ST_IDLE);

    // R2
    sdo_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!fall_i && !rise_i) |=> $stable(sdo_o));

    // R8
    idle_high_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE) |-> sdo_o);

    // R8
    idle_ignore_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE && !buf_full_i) |=> (state_q == ST_IDLE));

    // R6
    irq_set_chk: assert property (@(posedge clk) disable iff (rst)
        take_o |=> irq_o);

endmodule

// File: rtl/ext_sync_tx.sv
module ext_sync_tx #(
    parameter int   DATA_W      = 8,
    parameter int   SYNC_STAGES = 2,
    parameter logic SCLK_IDLE   = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              irq_clr,
    input  logic              err_clr,
    input  logic              sclk_in,
    output logic              sdo,
    output logic              buf_empty,
    output logic              irq_flag,
    output logic              ovr_err,
    output logic              tx_idle
);
    logic              edge_rise;
    logic              edge_fall;
    logic              take;
    logic              buf_full;
    logic [DATA_W-1:0] buf_data;

    sclk_sync #(
        .STAGES   (SYNC_STAGES),
        .IDLE_LVL (SCLK_IDLE)
    ) u_sync (
        .clk    (clk),
        .rst    (rst),
        .pin_i  (sclk_in),
        .rise_o (edge_rise),
        .fall_o (edge_fall)
    );

    tx_buffer #(
        .W (DATA_W)
    ) u_buf (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .take_i  (take),
        .err_clr (err_clr),
        .data_o  (buf_data),
        .full_o  (buf_full),
        .ovr_o   (ovr_err)
    );

    tx_shift_fsm #(
        .W (DATA_W)
    ) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .rise_i     (edge_rise),
        .fall_i     (edge_fall),
        .buf_full_i (buf_full),
        .buf_data_i (buf_data),
        .irq_clr    (irq_clr),
        .take_o     (take),
        .sdo_o      (sdo),
        .irq_o      (irq_flag),
        .idle_o     (tx_idle)
    );

    assign buf_empty = ~buf_full;

endmodule

// File: tb/ext_sync_tx_tb.sv
module ext_sync_tx_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       irq_clr = 1'b0;
    logic       err_clr = 1'b0;
    logic       sclk_in = 1'b1;
    logic       sdo, buf_empty, irq_flag, ovr_err, tx_idle;

    int  n_cmp = 0;
    int  n_bad = 0;
    bit  done  = 0;

    always #2 clk = ~clk;

    ext_sync_tx u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .irq_clr(irq_clr), .err_clr(err_clr), .sclk_in(sclk_in),
        .sdo(sdo), .buf_empty(buf_empty), .irq_flag(irq_flag),
        .ovr_err(ovr_err), .tx_idle(tx_idle)
    );

    // position of bit i in the captured stream: least significant first
    function automatic logic exp_bit(input logic [7:0] d, input int i);
        return d[i];
    endfunction

    function automatic int rand_phase();
        return 4 + int'($urandom_range(3, 0));
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic write_byte(input logic [7:0] d);
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic clock_bit(input int lw, input int hw, input logic do_wr,
                             input logic [7:0] d, output logic b);
        sclk_in = 1'b0;
        for (int j = 0; j < lw; j++) begin
            @(negedge clk);
            if (do_wr && j == 0) begin wr_en = 1'b1; wr_data = d; end
            else wr_en = 1'b0;
        end
        b = sdo;
        sclk_in = 1'b1;
        repeat (hw) @(negedge clk);
    endtask

    task automatic clock_frame(input bit rnd, output logic [7:0] got);
        for (int i = 0; i < 8; i++) begin
            logic b;
            clock_bit(rnd ? rand_phase() : 4, rnd ? rand_phase() : 4, 1'b0, 8'h00, b);
            got[i] = b;
        end
    endtask

    task automatic compare_frame(input string tag, input logic [7:0] got, input logic [7:0] d);
        logic [7:0] exp;
        for (int i = 0; i < 8; i++) exp[i] = exp_bit(d, i);
        check(tag, {24'd0, got}, {24'd0, exp});
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            finish_run();
        end
    end

    initial begin
        logic [7:0] got;
        logic [7:0] d [4];
        logic b;
        void'($urandom(32'd20240611));

        repeat (3) @(negedge clk);
        // R1 reset values
        check("R1 sdo", sdo, 1);
        check("R1 buf_empty", buf_empty, 1);
        check("R1 irq_flag", irq_flag, 0);
        check("R1 ovr_err", ovr_err, 0);
        check("R1 tx_idle", tx_idle, 1);
        rst = 1'b0;
        @(negedge clk);

        // R8 clock edges while idle leave the line high
        clock_frame(1'b0, got);
        check("R8 idle edges", {24'd0, got}, 32'hFF);
        check("R8 still idle", tx_idle, 1);

        // R3 single frame with the minimum start margin
        write_byte(8'hA5);
        repeat (4) @(negedge clk);
        check("R6 irq after take", irq_flag, 1);
        check("R7 empty after take", buf_empty, 1);
        clock_frame(1'b0, got);
        compare_frame("R3 first frame", got, 8'hA5);
        repeat (4) @(negedge clk);
        check("R8 idle after frame", tx_idle, 1);
        check("R8 line high", sdo, 1);
        clock_frame(1'b0, got);
        check("R8 edges ignored after frame", {24'd0, got}, 32'hFF);

        // R6 clear
        irq_clr = 1'b1; @(negedge clk); irq_clr = 1'b0;
        check("R6 irq cleared", irq_flag, 0);

        // R4 back-to-back, second byte written early
        write_byte(8'h3C);
        repeat (5) @(negedge clk);
        write_byte(8'hC3);
        check("R7 full after write", buf_empty, 0);
        clock_frame(1'b0, got);
        compare_frame("R4 frame A", got, 8'h3C);
        clock_frame(1'b0, got);
        compare_frame("R4 frame B no gap", got, 8'hC3);
        repeat (4) @(negedge clk);
        check("R8 idle after pair", tx_idle, 1);

        // R5 write during bit-7 low phase, 4-cycle high phase
        write_byte(8'h5A);
        repeat (5) @(negedge clk);
        for (int i = 0; i < 7; i++) begin
            clock_bit(4, 4, 1'b0, 8'h00, b);
            got[i] = b;
        end
        clock_bit(6, 4, 1'b1, 8'h96, b);
        got[7] = b;
        compare_frame("R5 frame before late write", got, 8'h5A);
        check("R5 late byte taken", tx_idle, 0);
        clock_frame(1'b0, got);
        compare_frame("R5 late frame", got, 8'h96);
        repeat (4) @(negedge clk);

        // R9 overrun
        write_byte(8'h11);
        repeat (5) @(negedge clk);
        write_byte(8'h22);
        write_byte(8'h33);
        check("R9 ovr set", ovr_err, 1);
        check("R9 buffer still full", buf_empty, 0);
        clock_frame(1'b0, got);
        compare_frame("R9 frame 1", got, 8'h11);
        clock_frame(1'b0, got);
        compare_frame("R9 kept byte", got, 8'h22);
        repeat (4) @(negedge clk);
        check("R9 discarded byte not sent", tx_idle, 1);
        check("R9 ovr sticky", ovr_err, 1);
        err_clr = 1'b1; @(negedge clk); err_clr = 1'b0;
        check("R9 ovr cleared", ovr_err, 0);

        // R2 R4 random chains with random phase widths
        for (int k = 0; k < 8; k++) begin
            int n = 1 + int'($urandom_range(3, 0));
            for (int f = 0; f < n; f++) d[f] = 8'($urandom());
            write_byte(d[0]);
            repeat (5 + int'($urandom_range(3, 0))) @(negedge clk);
            if (n > 1) write_byte(d[1]);
            for (int f = 0; f < n; f++) begin
                clock_frame(1'b1, got);
                compare_frame("R2 random frame", got, d[f]);
                if (f + 2 < n) write_byte(d[f + 2]);
            end
            repeat (4) @(negedge clk);
            check("R8 random chain ends idle", tx_idle, 1);
            check("R8 random chain line high", sdo, 1);
        end

        done = 1;
        finish_run();
    end
endmodule